// File: doc/BRIEF.md
# Bayer-Aware Horizontal Binning and Skipping

This block cuts the horizontal resolution of a raw Bayer pixel stream on its way through the digital readout path. Pixels arrive one per cycle with a valid strobe and a start-of-line marker. The block works on groups of four columns. Within a group, columns that are two apart carry the same colour plane. In binning mode, each pair from the same plane is replaced by its rounded average. In skipping mode, the first two columns of every group pass and the last two are dropped. Both modes keep the colour alternation of the output intact.

The row period is never shortened. Every output pixel leaves exactly one clock after the input pixel that completes it. Removed pixels appear only as gaps in the output valid. The mode is taken from a static input, but only on the start-of-line pixel, so a line is never split between two modes. Vertical binning, summing and row skipping are handled elsewhere in the chip.

Top module: `hbin_skip_top`

## Requirements
- R1: Mode code 2'b00 (off), and the reserved code 2'b11 treated as off, forward every valid input pixel unchanged to the output one clock later.
- R2: The mode input is sampled only on a valid pixel that carries the start-of-line marker. A change at any other time has no effect until the next such pixel.
- R3: With mode 2'b01 (bin), columns are numbered 0..3 within a group, counted from the start-of-line pixel. Column 2 produces avg(col0, col2) one clock after column 2 arrives. Column 3 produces avg(col1, col3) one clock after column 3 arrives. Columns 0 and 1 produce no output.
- R4: The binned average is (a + b + 1) >> 1 (half rounds up), computed without overflow up to full-scale inputs.
- R5: With mode 2'b10 (skip), columns 0 and 1 of each group are output unchanged one clock later, and columns 2 and 3 produce no output.
- R6: The output valid is high only in the clock after a valid input pixel. Cycles with input valid low produce no output and do not advance the column count.
- R7: A start-of-line pixel always restarts counting at column 0. Any partly filled group from the previous line is discarded.
- R8: While reset is low, and in the first clock after it, the output valid is low. After reset the mode is off and the column count is 0 until the first start-of-line pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 2 | Reduction mode: 00 off, 01 bin, 10 skip, 11 off |
| pix_valid_i | input | 1 | Input pixel present this cycle |
| pix_sol_i | input | 1 | Input pixel is the first of a line |
| pix_data_i | input | DATA_W | Input pixel value |
| out_valid_o | output | 1 | Output pixel present this cycle |
| out_data_o | output | DATA_W | Output pixel value |

## Verification
The bench places an idle cycle inside a binning group. A design that advanced the column count on idle cycles would pair pixels from the wrong colour planes. It changes the mode input in the middle of a line, where a design that is not gated to the start of line would start dropping or emitting pixels mid-line.

Full-scale pairs and odd sums check the carry bit and the half-up rounding. A truncating averager or a narrow adder would give a value one low or wrapped. A start-of-line pixel inside an unfinished group, and a reset in the middle of a binned line, show whether stale phase or mode survives. A design that kept either would emit an output where none is expected.

// File: rtl/hbin_pkg.sv
// Shared mode encoding for the horizontal binning/skipping block.
// Assumes a 2-bit mode field; the reserved code behaves as off.
package hbin_pkg;
    typedef enum logic [1:0] {
        HB_OFF  = 2'b00,
        HB_BIN  = 2'b01,
        HB_SKIP = 2'b10,
        HB_RSVD = 2'b11
    } hb_mode_e;
endpackage

// File: rtl/hbin_phase_track.sv
// Column phase and line mode tracker.
// Counts valid pixels modulo 2*SPAN from the start-of-line pixel and
// latches the mode on that pixel. Assumes SPAN is a power of two, 2 or more,
// and that pix_sol_i is only meaningful together with pix_valid_i.
module hbin_phase_track
    import hbin_pkg::*;
#(
    parameter int SPAN = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            valid_i,
    input  logic                            sol_i,
    input  logic [1:0]                      mode_i,
    output logic [$clog2(2*SPAN)-1:0]       phase_o,
    output hb_mode_e                        mode_o
);
    localparam int GROUP = 2 * SPAN;
    localparam int PH_W  = $clog2(GROUP);

    logic [PH_W-1:0] col_q;
    hb_mode_e        mode_q;
    logic            line_start;

    // Purpose: select phase and mode that apply to the current pixel.
    always_comb begin
        line_start = valid_i && sol_i;
        phase_o    = line_start ? '0 : col_q;
        mode_o     = line_start ? hb_mode_e'(mode_i) : mode_q;
    end

    // Purpose: advance the column count on valid pixels and hold the line mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q  <= '0;
            mode_q <= HB_OFF;
        end else if (valid_i) begin
            col_q <= phase_o + PH_W'(1);
            if (line_start) begin
                mode_q <= mode_o;
            end
        end
    end

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && sol_i) |=> $stable(mode_q)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(col_q)); // R6
endmodule

// File: rtl/hbin_pair_avg.sv
// Same-plane pair averager.
// Stores the pixels of the first half of a group, one slot per colour
// plane, and averages each with the pixel SPAN columns later, rounding
// half up. Assumes SPAN is a power of two, 2 or more.
module hbin_pair_avg #(
    parameter int DATA_W = 12,
    parameter int SPAN   = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            valid_i,
    input  logic [$clog2(2*SPAN)-1:0]       phase_i,
    input  logic [DATA_W-1:0]               data_i,
    output logic [DATA_W-1:0]               avg_o
);
    localparam int PH_W = $clog2(2 * SPAN);
    localparam int SL_W = PH_W - 1;

    logic [DATA_W-1:0] hold_q [SPAN];
    logic [SL_W-1:0]   slot;
    logic              first_half;
    logic [DATA_W:0]   sum;

    // Purpose: decode the storage slot and which half of the group this is.
    always_comb begin
        slot       = phase_i[SL_W-1:0];
        first_half = !phase_i[PH_W-1];
    end

    for (genvar s = 0; s < SPAN; s++) begin : g_slot
        // Purpose: capture the first pixel of the pair for colour plane s.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_q[s] <= '0;
            end else if (valid_i && first_half && (slot == SL_W'(s))) begin
                hold_q[s] <= data_i;
            end
        end
    end

    // Purpose: rounded average of stored partner and current pixel.
    always_comb begin
        sum   = {1'b0, hold_q[slot]} + {1'b0, data_i} + (DATA_W+1)'(1);
        avg_o = sum[DATA_W:1];
    end
endmodule

// File: rtl/hbin_skip_top.sv
// Horizontal binning / skipping stage for a raw Bayer stream.
// One pixel per clock in, registered result one clock later; removed
// pixels become gaps in out_valid_o so the row period is unchanged.
// Assumes the start-of-line marker accompanies the first valid pixel.
module hbin_skip_top
    import hbin_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int SPAN   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode_i,
    input  logic                pix_valid_i,
    input  logic                pix_sol_i,
    input  logic [DATA_W-1:0]   pix_data_i,
    output logic                out_valid_o,
    output logic [DATA_W-1:0]   out_data_o
);
    localparam int PH_W = $clog2(2 * SPAN);

    logic [PH_W-1:0]   phase;
    hb_mode_e          act_mode;
    logic [DATA_W-1:0] avg;
    logic              keep;
    logic              second_half;
    logic [DATA_W-1:0] sel_data;

    hbin_phase_track #(.SPAN(SPAN)) i_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (pix_valid_i),
        .sol_i   (pix_sol_i),
        .mode_i  (mode_i),
        .phase_o (phase),
        .mode_o  (act_mode)
    );

    hbin_pair_avg #(.DATA_W(DATA_W), .SPAN(SPAN)) i_avg (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (pix_valid_i),
        .phase_i (phase),
        .data_i  (pix_data_i),
        .avg_o   (avg)
    );

    // Purpose: decide whether this pixel yields an output and which value.
    always_comb begin
        second_half = phase[PH_W-1];
        unique case (act_mode)
            HB_BIN:  keep = second_half;
            HB_SKIP: keep = !second_half;
            default: keep = 1'b1;
        endcase
        keep     = keep && pix_valid_i;
        sel_data = (act_mode == HB_BIN) ? avg : pix_data_i;
    end

    // Purpose: output register, one clock of latency for every mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            out_data_o  <= '0;
        end else begin
            out_valid_o <= keep;
            if (keep) begin
                out_data_o <= sel_data;
            end
        end
    end

    AST_OUT_FOLLOWS_IN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(pix_valid_i)); // R6

    AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_i && (act_mode == HB_OFF || act_mode == HB_RSVD))
        |=> (out_valid_o && out_data_o == $past(pix_data_i))); // R1

    AST_SKIP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_i && act_mode == HB_SKIP && phase[PH_W-1]) |=> !out_valid_o); // R5

    AST_BIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_i && act_mode == HB_BIN && !phase[PH_W-1]) |=> !out_valid_o); // R3

    AST_SOL_NO_BIN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_i && pix_sol_i && mode_i == 2'b01) |=> !out_valid_o); // R7
endmodule

// File: tb/test_hbin_skip_top.sv
module test_hbin_skip_top;
    localparam int DW = 12;
    localparam int NV = 33;
    typedef logic [28:0] vec_t; // mode[28:27] sol[26] valid[25] data[24:13] ev[12] ed[11:0]

    localparam vec_t VEC [NV] = '{
        // R1 off mode, with idle gap
        {2'd0,1'b1,1'b1,12'd5,   1'b1,12'd5},
        {2'd0,1'b0,1'b1,12'd6,   1'b1,12'd6},
        {2'd0,1'b0,1'b0,12'd7,   1'b0,12'd0},
        {2'd0,1'b0,1'b1,12'd8,   1'b1,12'd8},
        // R3 bin line with idle cycle inside a group (R6)
        {2'd1,1'b1,1'b1,12'd100, 1'b0,12'd0},
        {2'd1,1'b0,1'b1,12'd200, 1'b0,12'd0},
        {2'd1,1'b0,1'b0,12'd0,   1'b0,12'd0},
        {2'd1,1'b0,1'b1,12'd101, 1'b1,12'd101},
        {2'd1,1'b0,1'b1,12'd300, 1'b1,12'd250},
        {2'd1,1'b0,1'b1,12'd10,  1'b0,12'd0},
        {2'd1,1'b0,1'b1,12'd11,  1'b0,12'd0},
        {2'd1,1'b0,1'b1,12'd13,  1'b1,12'd12},
        {2'd1,1'b0,1'b1,12'd0,   1'b1,12'd6},
        {2'd1,1'b0,1'b1,12'd4095,1'b0,12'd0},
        // R2 mode changes mid-line, ignored; R4 full scale
        {2'd2,1'b0,1'b1,12'd4095,1'b0,12'd0},
        {2'd2,1'b0,1'b1,12'd4094,1'b1,12'd4095},
        {2'd2,1'b0,1'b1,12'd1,   1'b1,12'd2048},
        // R5 skip line
        {2'd2,1'b1,1'b1,12'd20,  1'b1,12'd20},
        {2'd2,1'b0,1'b1,12'd21,  1'b1,12'd21},
        {2'd2,1'b0,1'b1,12'd22,  1'b0,12'd0},
        {2'd2,1'b0,1'b1,12'd23,  1'b0,12'd0},
        {2'd2,1'b0,1'b1,12'd24,  1'b1,12'd24},
        {2'd2,1'b0,1'b1,12'd25,  1'b1,12'd25},
        {2'd2,1'b0,1'b1,12'd26,  1'b0,12'd0},
        // R1 reserved code behaves as off
        {2'd3,1'b1,1'b1,12'd30,  1'b1,12'd30},
        {2'd3,1'b0,1'b1,12'd31,  1'b1,12'd31},
        // R7 start of line inside an unfinished group; R4 half-up rounding
        {2'd1,1'b1,1'b1,12'd2,   1'b0,12'd0},
        {2'd1,1'b0,1'b1,12'd3,   1'b0,12'd0},
        {2'd1,1'b1,1'b1,12'd4,   1'b0,12'd0},
        {2'd1,1'b0,1'b1,12'd5,   1'b0,12'd0},
        {2'd1,1'b0,1'b1,12'd7,   1'b1,12'd6},
        {2'd1,1'b0,1'b1,12'd8,   1'b1,12'd7},
        {2'd1,1'b0,1'b0,12'd0,   1'b0,12'd0}
    };
    localparam string VREQ [NV] = '{
        "R1","R1","R6","R1",
        "R3","R3","R6","R3","R3","R3","R3","R3","R3","R3",
        "R2","R4","R4",
        "R5","R5","R5","R5","R5","R5","R5",
        "R1","R1",
        "R7","R7","R7","R7","R4","R4","R6"
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    mode;
    logic          pv;
    logic          psol;
    logic [DW-1:0] pd;
    logic          ov;
    logic [DW-1:0] od;
    int            n_chk = 0;
    int            n_fail = 0;

    always #10 clk = ~clk;

    hbin_skip_top #(.DATA_W(DW), .SPAN(2)) i_hbin_skip_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode),
        .pix_valid_i (pv),
        .pix_sol_i   (psol),
        .pix_data_i  (pd),
        .out_valid_o (ov),
        .out_data_o  (od)
    );

    task automatic chk(input string req, input logic ev, input logic [DW-1:0] ed);
        n_chk++;
        if (ov !== ev || (ev && od !== ed)) begin
            n_fail++;
            $display("FAIL %s: valid=%0b data=%0d, expected valid=%0b data=%0d",
                     req, ov, od, ev, ed);
        end
    endtask

    // Drive one pixel at a falling edge, then sample at the next falling edge.
    task automatic step(input logic [1:0] m, input logic s, input logic v,
                        input logic [DW-1:0] d);
        mode = m; psol = s; pv = v; pd = d;
        @(negedge clk);
    endtask

    initial begin : wd
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode = 2'd0; psol = 1'b0; pv = 1'b0; pd = '0;
        repeat (3) @(negedge clk);
        chk("R8", 1'b0, '0);
        // input during reset must not appear
        step(2'd0, 1'b1, 1'b1, 12'd77);
        chk("R8", 1'b0, '0);
        rst_n = 1'b1;
        step(2'd0, 1'b0, 1'b0, 12'd0);
        chk("R8", 1'b0, '0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][28:27], VEC[i][26], VEC[i][25], VEC[i][24:13]);
            chk(VREQ[i], VEC[i][12], VEC[i][11:0]);
        end

        // R8: reset in the middle of a binned line clears mode and phase
        step(2'd1, 1'b1, 1'b1, 12'd50);
        step(2'd1, 1'b0, 1'b1, 12'd51);
        rst_n = 1'b0;
        step(2'd1, 1'b0, 1'b0, 12'd0);
        chk("R8", 1'b0, '0);
        rst_n = 1'b1;
        step(2'd1, 1'b0, 1'b1, 12'd9);
        chk("R8", 1'b1, 12'd9);
        step(2'd1, 1'b0, 1'b1, 12'd10);
        chk("R8", 1'b1, 12'd10);
        // R7: first start-of-line after reset: column 0 of a bin group
        step(2'd1, 1'b1, 1'b1, 12'd1);
        chk("R7", 1'b0, '0);
        step(2'd1, 1'b0, 1'b1, 12'd1);
        chk("R7", 1'b0, '0);
        step(2'd1, 1'b0, 1'b1, 12'd2);
        chk("R4", 1'b1, 12'd2);
        step(2'd1, 1'b0, 1'b0, 12'd0);
        chk("R6", 1'b0, '0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule